// File: doc/BRIEF.md
# Lookahead Counter-Match Trigger

The block keeps two counters of equal width and reports, one cycle late, whether they held the same value. The free counter advances on every clock. The gated counter advances while the enable input is high and drops to zero in any cycle where the enable is low. A user reads the flag as an ordinary registered equality: it is high in cycle n exactly when the counters matched in cycle n-1.

A single wide equality would be a deep logic path. Here the compare is cut into narrow slices whose results are registered. The extra cycles this adds are hidden by comparing values the counters will hold two cycles later. Only three futures of the gated counter exist: it kept counting, it was just cleared, or it was cleared and then counted once. One comparator set runs per future. Two registered samples of the enable then pick the set that came true. The datapath has no stream traffic, so every pin is a plain level signal with no valid/ready handshake.

Top module: `match_trigger`

## Requirements
- R1: Outside reset, `free_count` rises by one modulo 2^CNT_W on every rising clock edge.
- R2: Outside reset, on each rising edge `gated_count` becomes its value plus one (modulo 2^CNT_W) when `b_enable` is 1, and becomes zero when `b_enable` is 0.
- R3: Count cycle 0 as the first cycle after the last edge that sampled `rst` high. From cycle 3 on, `match_flag` in cycle n is 1 exactly when `free_count` equalled `gated_count` in cycle n-1.
- R4: `match_flag` is 0 in cycles 0, 1 and 2 after reset release, even where the counters are equal.
- R5: `rst` is synchronous and active high. After any edge that samples it high, both counters read zero and `match_flag` reads 0.
- R6: Both counters wrap from all ones to zero. Matches created by the wrap are flagged on time. This covers the gated counter being cleared as the free counter reaches zero, and the gated counter being cleared and then re-enabled so that both read one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| b_enable | input | 1 | 1 = gated counter advances, 0 = gated counter clears |
| match_flag | output | 1 | Registered equality of the two counters, one cycle late |
| free_count | output | CNT_W | Free-running counter value |
| gated_count | output | CNT_W | Enable-gated counter value |

## Verification
The bench builds the block with CNT_W = 12 and SLICE_W = 4. Each candidate is then split into three slices, and the free counter wraps every 4096 cycles. Both wrap-driven match cases can therefore be reached within a short run: the clear at the wrap, and the clear followed by re-enable. At the default 32-bit width neither case could be reached in a run. The narrow width also lets random enable streams cross a wrap while a reference model checks the flag every cycle.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;

  // Futures of the gated counter two cycles ahead
  typedef enum logic [1:0] {
    CAND_RUN  = 2'd0,  // kept counting: compare current values
    CAND_ZERO = 2'd1,  // cleared in the latest cycle
    CAND_ONE  = 2'd2   // cleared, then counted once
  } cand_e;

  localparam int NCAND = 3;

  // older/newer are enable samples of consecutive cycles
  function automatic cand_e pick_cand(input logic older, input logic newer);
    if (!newer)      return CAND_ZERO;
    else if (!older) return CAND_ONE;
    else             return CAND_RUN;
  endfunction

endpackage

// File: rtl/mt_counters.sv
`timescale 1ns/1ps
module mt_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] free_q,
  output logic [CNT_W-1:0] gated_q
);

  localparam logic [CNT_W-1:0] INC = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q  <= '0;
      gated_q <= '0;
    end else begin
      free_q  <= free_q + INC;
      gated_q <= en ? gated_q + INC : '0;
    end
  end

  assert_free_step_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> free_q == $past(free_q) + INC);

  assert_gated_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && en) |=> gated_q == $past(gated_q) + INC);

  assert_gated_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !en) |=> gated_q == '0);

  assert_free_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && free_q == '1) |=> free_q == '0);

endmodule

// File: rtl/mt_slice_cmp.sv
`timescale 1ns/1ps
module mt_slice_cmp
  import mt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SLICE_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [CNT_W-1:0]                      cnt_a,
  input  logic [CNT_W-1:0]                      cnt_b,
  output logic [NCAND-1:0][CNT_W/SLICE_W-1:0]   slice_eq_q
);

  localparam int NSLICE = CNT_W / SLICE_W;
  localparam logic [CNT_W-1:0] AHEAD = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0]                a_ahead;
  logic [NCAND-1:0][CNT_W-1:0]     lhs;
  logic [NCAND-1:0][CNT_W-1:0]     rhs;
  logic [NCAND-1:0][NSLICE-1:0]    eq_c;

  // Free counter two cycles on; wraps by modular addition
  assign a_ahead = cnt_a + AHEAD;

  always_comb begin
    // both advance by two: difference unchanged
    lhs[CAND_RUN]  = cnt_a;
    rhs[CAND_RUN]  = cnt_b;
    lhs[CAND_ZERO] = a_ahead;
    rhs[CAND_ZERO] = '0;
    lhs[CAND_ONE]  = a_ahead;
    rhs[CAND_ONE]  = ONE;
  end

  for (genvar c = 0; c < NCAND; c++) begin : g_cand
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      assign eq_c[c][s] = lhs[c][s*SLICE_W +: SLICE_W] == rhs[c][s*SLICE_W +: SLICE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) slice_eq_q <= '0;
    else     slice_eq_q <= eq_c;
  end

endmodule

// File: rtl/mt_select.sv
`timescale 1ns/1ps
module mt_select
  import mt_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [NCAND-1:0][NSLICE-1:0] slice_eq_q,
  output logic                         hit_q
);

  logic [NCAND-1:0] cand_hit_q;
  logic             en_d1;
  logic             en_d2;
  cand_e            sel;
  logic             sel_hit;

  assign sel = pick_cand(en_d2, en_d1);

  always_comb begin
    unique case (sel)
      CAND_ZERO: sel_hit = cand_hit_q[CAND_ZERO];
      CAND_ONE:  sel_hit = cand_hit_q[CAND_ONE];
      default:   sel_hit = cand_hit_q[CAND_RUN];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_hit_q <= '0;
      en_d1      <= 1'b0;
      en_d2      <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      for (int c = 0; c < NCAND; c++) cand_hit_q[c] <= &slice_eq_q[c];
      en_d1 <= en;
      en_d2 <= en_d1;
      hit_q <= sel_hit;
    end
  end

endmodule

// File: rtl/match_trigger.sv
`timescale 1ns/1ps
module match_trigger
  import mt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SLICE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             b_enable,
  output logic             match_flag,
  output logic [CNT_W-1:0] free_count,
  output logic [CNT_W-1:0] gated_count
);

  localparam int NSLICE = CNT_W / SLICE_W;

  logic [NCAND-1:0][NSLICE-1:0] slice_eq_q;

  mt_counters #(.CNT_W(CNT_W)) u_counters (
    .clk     (clk),
    .rst     (rst),
    .en      (b_enable),
    .free_q  (free_count),
    .gated_q (gated_count)
  );

  mt_slice_cmp #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_slice_cmp (
    .clk        (clk),
    .rst        (rst),
    .cnt_a      (free_count),
    .cnt_b      (gated_count),
    .slice_eq_q (slice_eq_q)
  );

  mt_select #(.NSLICE(NSLICE)) u_select (
    .clk        (clk),
    .rst        (rst),
    .en         (b_enable),
    .slice_eq_q (slice_eq_q),
    .hit_q      (match_flag)
  );

  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (free_count == '0 && gated_count == '0 && !match_flag));

  assert_fill_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rst, 2) || $past(rst, 3)) |-> !match_flag);

  assert_match_exact_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3))
      |-> match_flag == $past(free_count == gated_count));

endmodule

// File: tb/test_match_trigger.sv
`timescale 1ns/1ps
module test_match_trigger;

  localparam int W  = 12;
  localparam int SW = 4;

  // pattern[11:4] = enable per cycle 0..7, [3:0] = flag highs expected in cycles 0..15
  localparam logic [11:0] VECS [8] = '{
    12'hFF7, 12'h7F6, 12'h0F3, 12'h031, 12'h010, 12'h000, 12'hFD0, 12'h072
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         b_enable = 1'b0;
  logic         match_flag;
  logic [W-1:0] free_count;
  logic [W-1:0] gated_count;

  always #10 clk = ~clk;

  match_trigger #(.CNT_W(W), .SLICE_W(SW)) i_match_trigger (
    .clk         (clk),
    .rst         (rst),
    .b_enable    (b_enable),
    .match_flag  (match_flag),
    .free_count  (free_count),
    .gated_count (gated_count)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Single-cycle reference model
  logic [W-1:0] ra = '0;
  logic [W-1:0] rb = '0;
  logic         rtrig = 1'b0;
  int           since = 0;
  bit           in_rst = 1'b0;
  bit           started = 1'b0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      ra <= '0; rb <= '0; rtrig <= 1'b0; since <= 0; in_rst <= 1'b1;
    end else begin
      ra     <= ra + W'(1);
      rb     <= b_enable ? rb + W'(1) : '0;
      rtrig  <= (ra == rb);
      in_rst <= 1'b0;
      if (since < 1000) since <= since + 1;
    end
  end

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      if (in_rst) begin
        check(free_count == '0 && gated_count == '0 && !match_flag, "R5 reset",
              {free_count, gated_count, match_flag}, 0);
      end else begin
        check(free_count == ra, "R1 free", free_count, ra);
        check(gated_count == rb, "R2 gated", gated_count, rb);
        if (since <= 2) check(!match_flag, "R4 fill", match_flag, 0);
        else            check(match_flag == rtrig, "R3 match", match_flag, rtrig);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0]  pat;
    logic [3:0]  exp_hits;
    int          hits;
    logic [15:0] lfsr;

    repeat (3) @(negedge clk);

    // Vector table: each row starts from reset (R3, R4, R5)
    for (int v = 0; v < 8; v++) begin
      pat      = VECS[v][11:4];
      exp_hits = VECS[v][3:0];
      @(negedge clk);
      rst = 1'b1;
      b_enable = 1'b0;
      repeat (2) @(negedge clk);
      hits = 0;
      for (int c = 0; c < 16; c++) begin
        if (c > 0) @(negedge clk);
        hits += int'(match_flag);
        if (c == 0) rst = 1'b0;
        b_enable = (c < 8) ? pat[c] : 1'b0;
      end
      check(hits == int'(exp_hits), (v == 4) ? "R4 table" : "R3 table", hits, exp_hits);
    end

    // Wrap with clear at the wrap point (R6)
    @(negedge clk);
    rst = 1'b1;
    b_enable = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    while (free_count != W'(4094)) @(negedge clk);
    b_enable = 1'b1;
    @(negedge clk); b_enable = 1'b0;          // A = all ones
    @(negedge clk); b_enable = 1'b0;          // A = 0, B = 0
    check(gated_count == '0, "R6 cleared", gated_count, 0);
    @(negedge clk);                           // A = 1, B = 0
    check(match_flag == 1'b1, "R6 zero match", match_flag, 1);
    b_enable = 1'b1;
    @(negedge clk);                           // A = 2
    check(match_flag == 1'b0, "R6 after zero", match_flag, 0);

    // Wrap with clear then re-enable (R6)
    while (free_count != W'(4094)) @(negedge clk);
    b_enable = 1'b1;
    @(negedge clk); b_enable = 1'b0;          // A = all ones
    @(negedge clk); b_enable = 1'b1;          // A = 0, B = 0
    @(negedge clk);                           // A = 1, B = 1
    check(match_flag == 1'b1, "R6 wrap match", match_flag, 1);
    check(gated_count == W'(1), "R6 reenabled", gated_count, 1);
    @(negedge clk);                           // A = 2
    check(match_flag == 1'b1, "R6 one match", match_flag, 1);
    @(negedge clk);                           // A = 3
    check(match_flag == 1'b1, "R6 run match", match_flag, 1);

    // Random enable stream across a wrap, checked each cycle (R1, R2, R3)
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b_enable = lfsr[0] | lfsr[3];
    end

    // Mid-run reset with counters unequal (R5, R4)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(free_count == '0 && !match_flag, "R5 mid reset", free_count, 0);
    b_enable = 1'b1;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!match_flag, "R4 equal but quiet", match_flag, 0);
    repeat (2) @(negedge clk);
    check(match_flag == 1'b1, "R3 first valid", match_flag, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule